// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit turns a 16-bit segment base and a 16-bit offset into a 20-bit physical byte address, then carries out the memory access over a byte-wide port. It keeps four segment registers: code, data, stack and extra. A request carries an access kind, an offset, a size (byte or word) and a direction. The access kind picks the segment register that supplies the base. Fetches use code, data accesses use data, stack accesses use stack, and the extra segment is used only when the kind asks for it by name. Software loads the segment registers through a separate write port with a 2-bit select.

A word access is split into two byte cycles on the memory port. The low-order byte goes to the computed address and the high-order byte goes to the next address up. Each byte cycle completes on a valid/ready handshake. When the last byte completes, a one-cycle done pulse is raised. For a read, the two bytes are reassembled into one 16-bit result. The unit accepts a new request only while it is idle.

Top module: `seg_agu_top`

## Requirements
- R1: The physical address is (segment × 16 + offset) modulo 2^20. Any carry beyond bit 19 is dropped, so the address wraps to low memory. For example, 020A:1BCD gives 03C6D and FFFF:FFFF gives 0FFEF.
- R2: The access kind encoding is 0 for fetch (code segment), 1 for data (data segment), 2 for stack (stack segment) and 3 for extra (extra segment). The segment write select uses the same index per register.
- R3: Synchronous reset clears all four segment registers to zero. After reset, req_ready is 1, mem_valid is 0 and done is 0.
- R4: A byte access performs exactly one memory cycle, at the physical address. A byte read returns the byte in rd_data[7:0], with rd_data[15:8] equal to zero.
- R5: A word access performs exactly two memory cycles. The first, at address P, carries wdata[7:0]. The second, at (P+1) modulo 2^20, carries wdata[15:8].
- R6: A word read returns {byte at P+1, byte at P} in rd_data.
- R7: done is high for exactly one cycle: the cycle after the clock edge of the final byte handshake. rd_data holds the result from that cycle until the next read completes.
- R8: req_ready is high only while no transfer is in progress. A req_valid that arrives during a transfer is ignored and starts no memory cycle.
- R9: While mem_valid is high and mem_ready is low, mem_valid stays high and mem_addr, mem_we and mem_wdata hold their values.
- R10: A segment write takes effect for requests accepted after its clock edge. A request accepted in the same cycle as the write uses the old value. A write made during a transfer does not alter that transfer's addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_we | input | 1 | Segment register write enable |
| seg_sel | input | 2 | Segment register index to write |
| seg_wdata | input | 16 | Segment value to write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_kind | input | 2 | Access kind, selects default segment |
| req_off | input | 16 | Offset within the segment |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| mem_valid | output | 1 | Byte cycle requested |
| mem_ready | input | 1 | Memory accepts the byte cycle |
| mem_addr | output | 20 | Physical byte address |
| mem_we | output | 1 | Byte cycle is a write |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid with mem_ready |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result |

## Verification
Some rules are checked by assertions on every cycle. These are that a stalled byte cycle holds its address and data, that done never lasts two cycles, that an accepted request raises mem_valid at once, that the second byte address is one above the first, and that segment registers change only on a write. Other behaviours are shown only by the bench scenarios. These are the address arithmetic itself, including the 20-bit wraparound, the choice of segment per access kind, the byte order and reassembly of words, requests ignored while busy, and the old-versus-new value of a segment written in the same cycle as a request.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_DATA  = 2'd1,
    KIND_STACK = 2'd2,
    KIND_EXTRA = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LO   = 2'd1,
    SQ_HI   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int SEG_W   = 16,
  parameter int NUM_SEG = 4,
  localparam int SEL_W  = $clog2(NUM_SEG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] wsel,
  input  logic [SEG_W-1:0] wdata,
  input  logic [SEL_W-1:0] rsel,
  output logic [SEG_W-1:0] rdata
);
  logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= '0;
    end else begin
      for (int i = 0; i < NUM_SEG; i++) begin
        if (we && (wsel == SEL_W'(i))) seg_q[i] <= wdata;
      end
    end
  end

  assign rdata = seg_q[rsel];

  // R10
  seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(seg_q));
endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20,
  localparam int SUM_W = ((SEG_W + SHIFT) > OFF_W ? (SEG_W + SHIFT) : OFF_W) + 1
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] phys
);
  logic [SUM_W-1:0] seg_ext;
  logic [SUM_W-1:0] off_ext;
  logic [SUM_W-1:0] sum;

  always_comb begin
    seg_ext = SUM_W'(seg) << SHIFT;
    off_ext = SUM_W'(off);
    sum     = seg_ext + off_ext;
    phys    = sum[ADDR_W-1:0];
  end
endmodule

// File: rtl/seg_byte_seq.sv
module seg_byte_seq
  import seg_agu_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int BYTE_W  = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  seq_state_e        state;
  logic              word_q;
  logic [BYTE_W-1:0] hi_q;
  logic [BYTE_W-1:0] lo_q;

  assign req_ready = (state == SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      done      <= 1'b0;
      rd_data   <= '0;
      word_q    <= 1'b0;
      hi_q      <= '0;
      lo_q      <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (req_valid) begin
            state     <= SQ_LO;
            mem_valid <= 1'b1;
            mem_addr  <= req_addr;
            mem_we    <= req_write;
            mem_wdata <= req_wdata[BYTE_W-1:0];
            hi_q      <= req_wdata[DATA_W-1:BYTE_W];
            word_q    <= req_word;
          end
        end
        SQ_LO: begin
          if (mem_ready) begin
            if (word_q) begin
              lo_q      <= mem_rdata;
              mem_addr  <= mem_addr + ADDR_W'(1);
              mem_wdata <= hi_q;
              state     <= SQ_HI;
            end else begin
              mem_valid <= 1'b0;
              done      <= 1'b1;
              if (!mem_we) rd_data <= {{BYTE_W{1'b0}}, mem_rdata};
              state     <= SQ_IDLE;
            end
          end
        end
        SQ_HI: begin
          if (mem_ready) begin
            mem_valid <= 1'b0;
            done      <= 1'b1;
            if (!mem_we) rd_data <= {mem_rdata, lo_q};
            state     <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  accept_start_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_valid && !req_ready));

  // R5
  hi_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_LO && mem_valid && mem_ready && word_q) |=>
      (mem_valid && mem_addr == $past(mem_addr) + ADDR_W'(1)));
endmodule

// File: rtl/seg_agu_top.sv
module seg_agu_top
  import seg_agu_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int OFF_W   = 16,
  parameter int SHIFT   = 4,
  parameter int ADDR_W  = 20,
  parameter int BYTE_W  = 8,
  parameter int NUM_SEG = 4,
  localparam int SEL_W  = $clog2(NUM_SEG),
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seg_we,
  input  logic [SEL_W-1:0]  seg_sel,
  input  logic [SEG_W-1:0]  seg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_kind,
  input  logic [OFF_W-1:0]  req_off,
  input  logic              req_word,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  logic [SEG_W-1:0]  seg_base;
  logic [ADDR_W-1:0] phys;

  seg_regfile #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (seg_we),
    .wsel  (seg_sel),
    .wdata (seg_wdata),
    .rsel  (req_kind),
    .rdata (seg_base)
  );

  seg_addr_calc #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_calc (
    .seg  (seg_base),
    .off  (req_off),
    .phys (phys)
  );

  seg_byte_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (phys),
    .req_word  (req_word),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .done      (done),
    .rd_data   (rd_data)
  );
endmodule

// File: tb/test_seg_agu_top.sv
`timescale 1ns/1ps
module test_seg_agu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seg_we = 1'b0;
  logic [1:0]  seg_sel = '0;
  logic [15:0] seg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [15:0] req_off = '0;
  logic        req_word = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [19:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        done;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  seg_agu_top i_seg_agu_top (
    .clk(clk), .rst(rst), .seg_we(seg_we), .seg_sel(seg_sel), .seg_wdata(seg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind), .req_off(req_off),
    .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done), .rd_data(rd_data)
  );

  function automatic logic [7:0] fbyte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]};
  endfunction

  assign mem_rdata = fbyte(mem_addr);

  logic [19:0] log_addr [64];
  logic        log_we   [64];
  logic [7:0]  log_data [64];
  int          log_n = 0;

  always @(posedge clk) begin
    if (!rst && mem_valid && mem_ready) begin
      log_addr[log_n % 64] <= mem_addr;
      log_we[log_n % 64]   <= mem_we;
      log_data[log_n % 64] <= mem_wdata;
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic seg_write(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    seg_we = 1'b1; seg_sel = sel; seg_wdata = val;
    @(negedge clk);
    seg_we = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 100; i++) begin
      if (done) return;
      @(negedge clk);
    end
    chk(1'b0, "watchdog-done", 0, 1);
  endtask

  task automatic xfer(input logic [1:0] kind, input bit word, input bit wr,
                      input logic [15:0] off, input logic [15:0] wd, output int start);
    @(negedge clk);
    start = log_n;
    req_valid = 1'b1; req_kind = kind; req_off = off;
    req_word = word; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
  endtask

  task automatic verify(input int start, input bit word, input bit wr,
                        input logic [19:0] p, input logic [15:0] wd, input string tag);
    logic [19:0] p1;
    p1 = p + 20'd1;
    chk((log_n - start) == (word ? 2 : 1), word ? "R5 cycle count" : "R4 cycle count",
        log_n - start, word ? 2 : 1);
    chk(log_addr[start % 64] == p, {"R1 address ", tag}, log_addr[start % 64], p);
    if (word) chk(log_addr[(start + 1) % 64] == p1, {"R5 high address ", tag},
                  log_addr[(start + 1) % 64], p1);
    if (wr) begin
      chk(log_data[start % 64] == wd[7:0], {"R5 low byte ", tag}, log_data[start % 64], wd[7:0]);
      if (word) chk(log_data[(start + 1) % 64] == wd[15:8], {"R5 high byte ", tag},
                    log_data[(start + 1) % 64], wd[15:8]);
    end else if (word) begin
      chk(rd_data == {fbyte(p1), fbyte(p)}, {"R6 word read ", tag}, rd_data, {fbyte(p1), fbyte(p)});
    end else begin
      chk(rd_data == {8'h00, fbyte(p)}, {"R4 byte read ", tag}, rd_data, {8'h00, fbyte(p)});
    end
  endtask

  // {kind, word, write, seg, off, wdata}
  localparam logic [51:0] VEC [8] = '{
    {2'd0, 1'b1, 1'b0, 16'h24F6, 16'h634A, 16'h0000},
    {2'd1, 1'b0, 1'b0, 16'h020A, 16'h1BCD, 16'h0000},
    {2'd2, 1'b1, 1'b1, 16'h3500, 16'hFFFE, 16'h0529},
    {2'd3, 1'b1, 1'b0, 16'h7FA2, 16'h438E, 16'h0000},
    {2'd1, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 16'h00A5},
    {2'd2, 1'b1, 1'b1, 16'hF000, 16'hFFFF, 16'hBEEF},
    {2'd0, 1'b0, 1'b0, 16'h2500, 16'h95F3, 16'h0000},
    {2'd1, 1'b1, 1'b0, 16'hFFFF, 16'h0010, 16'h0000}
  };

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int st;
    logic [19:0] p;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3 reset state
    chk(req_ready == 1'b1, "R3 req_ready", req_ready, 1);
    chk(mem_valid == 1'b0, "R3 mem_valid", mem_valid, 0);
    chk(done == 1'b0, "R3 done", done, 0);
    xfer(2'd1, 1'b0, 1'b0, 16'h1234, 16'h0, st);
    verify(st, 1'b0, 1'b0, 20'h01234, 16'h0, "R3 zero segment");

    for (int v = 0; v < 8; v++) begin
      logic [51:0] e;
      e = VEC[v];
      seg_write(e[51:50], e[47:32]);
      p = ({e[47:32], 4'h0} + {4'h0, e[31:16]}) & 20'hFFFFF;
      xfer(e[51:50], e[49], e[48], e[31:16], e[15:0], st);
      verify(st, e[49], e[48], p, e[15:0], $sformatf("vec%0d", v));
      @(negedge clk);
      chk(done == 1'b0, "R7 done one cycle", done, 0);
    end

    // R2 default segment per kind
    seg_write(2'd0, 16'h1000);
    seg_write(2'd1, 16'h2000);
    seg_write(2'd2, 16'h3000);
    seg_write(2'd3, 16'h4000);
    for (int k = 0; k < 4; k++) begin
      p = 20'h10005 + 20'(k) * 20'h10000;
      xfer(2'(k), 1'b0, 1'b0, 16'h0005, 16'h0, st);
      chk(log_addr[st % 64] == p, "R2 segment select", log_addr[st % 64], p);
    end

    // R10 same-cycle segment write uses old value
    @(negedge clk);
    st = log_n;
    seg_we = 1'b1; seg_sel = 2'd1; seg_wdata = 16'h5000;
    req_valid = 1'b1; req_kind = 2'd1; req_off = 16'h0000; req_word = 1'b0; req_write = 1'b0;
    @(negedge clk);
    seg_we = 1'b0; req_valid = 1'b0;
    wait_done();
    chk(log_addr[st % 64] == 20'h20000, "R10 same-cycle old value", log_addr[st % 64], 20'h20000);
    xfer(2'd1, 1'b0, 1'b0, 16'h0000, 16'h0, st);
    chk(log_addr[st % 64] == 20'h50000, "R10 new value", log_addr[st % 64], 20'h50000);

    // R8 / R9 / R10 busy with stalled memory
    @(negedge clk);
    mem_ready = 1'b0;
    st = log_n;
    req_valid = 1'b1; req_kind = 2'd2; req_off = 16'h0010; req_word = 1'b1;
    req_write = 1'b1; req_wdata = 16'h1234;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk(req_ready == 1'b0, "R8 busy not ready", req_ready, 0);
      chk(mem_valid == 1'b1 && mem_addr == 20'h30010, "R9 stall hold", mem_addr, 20'h30010);
      req_valid = 1'b1; req_off = 16'h0F00;
      seg_we = 1'b1; seg_sel = 2'd2; seg_wdata = 16'h6000;
      @(negedge clk);
    end
    req_valid = 1'b0; seg_we = 1'b0;
    mem_ready = 1'b1;
    wait_done();
    chk((log_n - st) == 2, "R8 ignored request", log_n - st, 2);
    chk(log_addr[(st + 1) % 64] == 20'h30011, "R10 in-flight address", log_addr[(st + 1) % 64], 20'h30011);
    chk(log_data[(st + 1) % 64] == 8'h12, "R5 stalled high byte", log_data[(st + 1) % 64], 8'h12);
    repeat (3) @(negedge clk);
    chk(log_n - st == 2, "R8 no extra cycle", log_n - st, 2);

    finish_run();
  end
endmodule